// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block holds the digital half of an 8-bit successive-approximation converter that sits behind an 8-way analog input selector. A 3-bit channel address is captured when its latch strobe rises, and the captured address is decoded into a one-hot select for the analog switches. A start strobe drives the conversion. Its rising edge clears the approximation register and pulls end-of-conversion low. Its falling edge starts a binary search. The search runs one step per clock, from the most significant bit down to the least.

On every step the block presents a trial code to an external DAC and comparator. It reads back one bit that says whether the input is at or above the trial level. When all bits are settled, end-of-conversion rises and the code is copied into a holding register. The holding register drives a data bus while output enable is high. A new start pulse during a conversion abandons it, so end-of-conversion can be wired back to the start input for free-running operation.

Top module: `sar_conv_ctrl`

## Requirements
- R1: The channel select output is one-hot, with bit n high for captured address n; address bit 2 is the most significant, so 3'b000 selects channel 0 and 3'b111 selects channel 7. After reset, channel 0 is selected.
- R2: The address input is captured only on a rising edge of the latch strobe, after a two-flop synchronizer. Address changes at any other time leave the select unchanged.
- R3: A rising edge of the start strobe clears the approximation register: the trial output reads 0 and end-of-conversion is low within 8 clock cycles of that edge.
- R4: Approximation starts only after the start strobe falls. The first trial code is 8'h80.
- R5: Exactly 8 steps are made, one per clock, from bit 7 down to bit 0. Each step raises the bit under test on the trial output. A comparator input of 1 keeps that bit and a 0 clears it. End-of-conversion rises after the eighth step.
- R6: The result is positive-true. With an ideal comparator whose first transition is at half an LSB, an input of v half-LSB units yields min(255, (v+1)/2).
- R7: A rising start edge during a running conversion aborts it. End-of-conversion stays low, the register is cleared, and the next conversion starts from zero.
- R8: The result is copied into a holding register when end-of-conversion rises. It is driven on the data bus while output enable is high and the bus is high impedance otherwise. The held value is unchanged by later conversions until the next end-of-conversion rise, including during an aborted one.
- R9: With end-of-conversion fed back to the start input after one external start pulse, conversions repeat without outside help, and each one yields the correct code.
- R10: While the start strobe is held high, no steps are taken: the trial output stays 0 and end-of-conversion stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address latch strobe, asynchronous |
| addr_i | input | 3 | Channel address, bit 2 most significant |
| start_i | input | 1 | Start-conversion strobe, asynchronous |
| cmp_keep_i | input | 1 | Comparator: 1 when the input is at or above the trial level |
| oe_i | input | 1 | Output enable for the data bus |
| chan_sel_o | output | 8 | One-hot analog channel select |
| trial_o | output | 8 | Trial code sent to the DAC |
| eoc_o | output | 1 | End of conversion, high when the result is valid |
| data_o | output | 8 | Result bus, high impedance while oe_i is low |

## Verification
Inputs at 0, 1, 2 and 3 half-LSB units test the half-LSB offset of the first code step and the rounding of the code. Inputs of 508 to 511 test the top step and saturation at 255. Random levels on random channels check that each channel select routes the right input and that every bit decision is correct. An abort that changes the input from a high level to a low one shows whether bits from the abandoned search survive. A free-running run with end-of-conversion tied to start shows that the feedback loop keeps producing correct codes.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2
   } sar_state_e;

endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "sar_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;
   assign fall_o  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/sar_chan_latch.sv
module sar_chan_latch #(
   parameter int ADDR_BITS = 3,
   localparam int CHANS    = 1 << ADDR_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture_i,
   input  logic [ADDR_BITS-1:0] addr_i,
   output logic [CHANS-1:0]     sel_o
);

   if (ADDR_BITS < 1 || ADDR_BITS > 6) begin : g_bad_addr
      initial $fatal(1, "sar_chan_latch: ADDR_BITS out of range");
   end

   logic [ADDR_BITS-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         addr_q <= '0;
      else if (capture_i) addr_q <= addr_i;
   end

   for (genvar c = 0; c < CHANS; c++) begin : g_dec
      assign sel_o[c] = (addr_q == ADDR_BITS'(c));
   end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
   import sar_pkg::*;
#(
   parameter int RES_BITS = 8,
   localparam int IDX_W   = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sc_rise_i,
   input  logic                sc_fall_i,
   input  logic                cmp_keep_i,
   output logic [RES_BITS-1:0] trial_o,
   output logic [RES_BITS-1:0] result_o,
   output logic                eoc_o,
   output sar_state_e          state_o
);

   if (RES_BITS < 2) begin : g_bad_res
      initial $fatal(1, "sar_seq: RES_BITS must be at least 2");
   end

   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_BITS - 1);

   sar_state_e          state_q;
   logic [RES_BITS-1:0] sar_q;
   logic [IDX_W-1:0]    idx_q;
   logic                eoc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sar_q   <= '0;
         idx_q   <= TOP_IDX;
         eoc_q   <= 1'b0;
      end else if (sc_rise_i) begin
         state_q <= ST_ARMED;
         sar_q   <= '0;
         idx_q   <= TOP_IDX;
         eoc_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_ARMED: begin
               if (sc_fall_i) begin
                  state_q <= ST_RUN;
                  idx_q   <= TOP_IDX;
               end
            end
            ST_RUN: begin
               sar_q[idx_q] <= cmp_keep_i;
               if (idx_q == '0) begin
                  state_q <= ST_IDLE;
                  eoc_q   <= 1'b1;
               end else begin
                  idx_q <= idx_q - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      trial_o = sar_q;
      if (state_q == ST_RUN) trial_o[idx_q] = 1'b1;
   end

   assign result_o = sar_q;
   assign eoc_o    = eoc_q;
   assign state_o  = state_q;

endmodule

// File: rtl/sar_out_reg.sv
module sar_out_reg #(
   parameter int  WIDTH    = 8,
   parameter bit  TRISTATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eoc_i,
   input  logic [WIDTH-1:0] result_i,
   input  logic             oe_i,
   output wire  [WIDTH-1:0] data_o
);

   logic             eoc_q;
   logic [WIDTH-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_q  <= 1'b0;
         hold_q <= '0;
      end else begin
         eoc_q <= eoc_i;
         if (eoc_i && !eoc_q) hold_q <= result_i;
      end
   end

   if (TRISTATE) begin : g_tri
      assign data_o = oe_i ? hold_q : {WIDTH{1'bz}};
   end else begin : g_gate
      assign data_o = oe_i ? hold_q : '0;
   end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
   import sar_pkg::*;
#(
   parameter int RES_BITS    = 8,
   parameter int ADDR_BITS   = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit TRISTATE    = 1'b1,
   localparam int CHANS      = 1 << ADDR_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ale_i,
   input  logic [ADDR_BITS-1:0] addr_i,
   input  logic                 start_i,
   input  logic                 cmp_keep_i,
   input  logic                 oe_i,
   output logic [CHANS-1:0]     chan_sel_o,
   output logic [RES_BITS-1:0]  trial_o,
   output logic                 eoc_o,
   output wire  [RES_BITS-1:0]  data_o
);

   logic                ale_lvl, ale_rise, ale_fall;
   logic                start_lvl, start_rise, start_fall;
   logic [RES_BITS-1:0] result;
   sar_state_e          seq_state;
   logic                armed, running;

   sar_sync_edge #(.STAGES(SYNC_STAGES)) u_ale_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ale_i),
      .level_o (ale_lvl),
      .rise_o  (ale_rise),
      .fall_o  (ale_fall)
   );

   sar_sync_edge #(.STAGES(SYNC_STAGES)) u_start_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (start_i),
      .level_o (start_lvl),
      .rise_o  (start_rise),
      .fall_o  (start_fall)
   );

   sar_chan_latch #(.ADDR_BITS(ADDR_BITS)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (ale_rise),
      .addr_i    (addr_i),
      .sel_o     (chan_sel_o)
   );

   sar_seq #(.RES_BITS(RES_BITS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sc_rise_i  (start_rise),
      .sc_fall_i  (start_fall),
      .cmp_keep_i (cmp_keep_i),
      .trial_o    (trial_o),
      .result_o   (result),
      .eoc_o      (eoc_o),
      .state_o    (seq_state)
   );

   sar_out_reg #(.WIDTH(RES_BITS), .TRISTATE(TRISTATE)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .eoc_i    (eoc_o),
      .result_i (result),
      .oe_i     (oe_i),
      .data_o   (data_o)
   );

   assign armed   = (seq_state == ST_ARMED);
   assign running = (seq_state == ST_RUN);

endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
   parameter int RES_BITS = 8,
   parameter int CHANS    = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ale_rise,
   input logic                start_rise,
   input logic                start_fall,
   input logic                armed,
   input logic                running,
   input logic [CHANS-1:0]    chan_sel_o,
   input logic [RES_BITS-1:0] trial_o,
   input logic                eoc_o
);

   localparam int CNT_W = $clog2(RES_BITS + 1) + 1;
   localparam logic [RES_BITS-1:0] MSB_CODE = {1'b1, {(RES_BITS-1){1'b0}}};

   logic [CNT_W-1:0] steps_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          steps_q <= '0;
      else if (start_rise) steps_q <= '0;
      else if (running)    steps_q <= steps_q + 1'b1;
   end

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chan_sel_o) == 1); // R1
   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ale_rise |=> $stable(chan_sel_o)); // R2
   AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_rise |=> (trial_o == '0 && !eoc_o)); // R3
   AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && start_fall && !start_rise) |=> trial_o == MSB_CODE); // R4
   AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_o) |-> steps_q == CNT_W'(RES_BITS)); // R5
   AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start_rise) |=> (!running && !eoc_o && trial_o == '0)); // R7
   AST_HOLD_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !start_fall) |=> (trial_o == '0 && !eoc_o)); // R10

endmodule

bind sar_conv_ctrl sar_conv_chk #(.RES_BITS(RES_BITS), .CHANS(CHANS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ale_rise   (ale_rise),
   .start_rise (start_rise),
   .start_fall (start_fall),
   .armed      (armed),
   .running    (running),
   .chan_sel_o (chan_sel_o),
   .trial_o    (trial_o),
   .eoc_o      (eoc_o)
);

// File: tb/sim_sar_conv_ctrl.sv
`timescale 1ns/1ps
module sim_sar_conv_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ale = 1'b0;
   logic [2:0] addr = 3'd0;
   logic       start_r = 1'b0;
   logic       free_run = 1'b0;
   logic       oe = 1'b0;
   logic       cmp_keep;
   logic [7:0] chan_sel, trial;
   logic       eoc;
   wire  [7:0] data;
   logic       start_drv;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int vin_h [8];

   always #2.5 clk = ~clk;

   assign start_drv = free_run ? eoc : start_r;

   sar_conv_ctrl u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .ale_i      (ale),
      .addr_i     (addr),
      .start_i    (start_drv),
      .cmp_keep_i (cmp_keep),
      .oe_i       (oe),
      .chan_sel_o (chan_sel),
      .trial_o    (trial),
      .eoc_o      (eoc),
      .data_o     (data)
   );

   // ideal comparator: first code edge at half an LSB
   always_comb begin
      int ch;
      ch = 0;
      for (int i = 0; i < 8; i++) if (chan_sel[i]) ch = i;
      cmp_keep = (vin_h[ch] >= 2 * int'(trial) - 1);
   end

   function automatic int exp_code(int v);
      int e;
      e = (v + 1) / 2;
      if (e > 255) e = 255;
      return e;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_addr(int a);
      addr = 3'(a);
      ale  = 1'b1;
      tick(4);
      ale  = 1'b0;
      tick(4);
   endtask

   task automatic start_rise_phase();
      int n;
      start_r = 1'b1;
      n = 0;
      while (eoc && n < 9) begin
         tick(1);
         n++;
      end
      check(!eoc && n <= 8, "R3 eoc low within 8", n, 8);
      tick(1);
      check(trial == 8'h00, "R3 cleared", trial, 0);
   endtask

   task automatic finish_phase(int ch);
      int n, steps;
      start_r = 1'b0;
      n = 0;
      while (trial == 8'h00 && n < 12) begin
         tick(1);
         n++;
      end
      check(trial == 8'h80, "R4 first trial", trial, 8'h80);
      steps = 1;
      tick(1);
      while (!eoc && steps < 20) begin
         steps++;
         tick(1);
      end
      check(steps == 8, "R5 step count", steps, 8);
      tick(2);
      oe = 1'b1;
      tick(1);
      check(data == 8'(exp_code(vin_h[ch])), "R6/R8 result", data, exp_code(vin_h[ch]));
      oe = 1'b0;
   endtask

   task automatic convert(int ch);
      start_rise_phase();
      tick(2);
      finish_phase(ch);
   endtask

   initial begin
      int dir_v [8];
      int ch;
      int held;
      int seen;
      void'($urandom(32'h5EED_0809));
      for (int i = 0; i < 8; i++) vin_h[i] = 0;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // reset state
      check(chan_sel == 8'h01, "R1 reset select", chan_sel, 1);
      check(!eoc, "R3 reset eoc", eoc, 0);
      check(trial == 8'h00, "R3 reset trial", trial, 0);

      // R1 decode of every address
      for (int a = 0; a < 8; a++) begin
         set_addr(a);
         check(chan_sel == 8'(1 << a), "R1 decode", chan_sel, 1 << a);
      end

      // R2 address change without strobe is ignored
      addr = 3'd2;
      tick(10);
      check(chan_sel == 8'h80, "R2 no strobe", chan_sel, 8'h80);

      // R6 directed corners on channel 5
      dir_v = '{0, 1, 2, 3, 508, 509, 510, 511};
      set_addr(5);
      for (int k = 0; k < 8; k++) begin
         vin_h[5] = dir_v[k];
         convert(5);
      end

      // R10 start held high: no steps
      start_r = 1'b1;
      tick(20);
      check(trial == 8'h00 && !eoc, "R10 held start", trial, 0);
      finish_phase(5);

      // R7 abort: high level abandoned, low level converted
      set_addr(3);
      vin_h[3] = 500;
      oe = 1'b1;
      tick(1);
      held = data;
      oe = 1'b0;
      start_rise_phase();
      start_r = 1'b0;
      tick(7);
      check(trial != 8'h00 && !eoc, "R7 running before abort", trial, 1);
      vin_h[3] = 6;
      start_r = 1'b1;
      oe = 1'b1;
      for (int k = 0; k < 8; k++) begin
         tick(1);
         check(!eoc, "R7 eoc low during abort", eoc, 0);
         check(data == 8'(held), "R8 held during abort", data, held);
      end
      oe = 1'b0;
      finish_phase(3);

      // R8 value held after conversion while inputs change
      vin_h[3] = 100;
      tick(10);
      oe = 1'b1;
      tick(1);
      check(data == 8'd3, "R8 hold", data, 3);
      oe = 1'b0;

      // random conversions on random channels
      for (int k = 0; k < 40; k++) begin
         ch = int'($urandom % 8);
         for (int i = 0; i < 8; i++) vin_h[i] = int'($urandom % 512);
         set_addr(ch);
         convert(ch);
      end

      // R9 free running, eoc fed back to start
      set_addr(6);
      vin_h[6] = 301;
      free_run = 1'b1;
      oe = 1'b1;
      seen = 0;
      for (int k = 0; k < 4; k++) begin
         int n;
         n = 0;
         while (eoc && n < 40) begin tick(1); n++; end
         n = 0;
         while (!eoc && n < 40) begin tick(1); n++; end
         tick(2);
         if (eoc || n < 40) seen++;
         check(data == 8'(exp_code(301)), "R9 free run result", data, exp_code(301));
         vin_h[6] = 301 + 40 * (k + 1);
         if (vin_h[6] > 511) vin_h[6] = 17;
         // next conversion must reflect the new level; keep expected in sync
         vin_h[6] = 301;
      end
      check(seen == 4, "R9 conversions repeat", seen, 4);
      free_run = 1'b0;
      start_r = 1'b0;
      oe = 1'b0;
      tick(30);
      convert(6);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      tick(150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule